// File: doc/BRIEF.md
# Lane-Partitioned Integer Multiplier

This block multiplies two 64-bit integer operands. The datapath is cut at byte boundaries into independent lanes. It is arranged as two 32-bit halves, and each half takes its own operation code and its own lane size. A half can work as one 32-bit lane, two 16-bit lanes or four 8-bit lanes. Both halves can also be fused into a single 64-bit multiply. For every lane the caller chooses the low half of the full-width product, or the high half under one of three signedness rules. No carry and no partial product ever crosses a lane boundary.

Work moves through three named pipeline stages. The capture stage registers operands and control. The multiply stage forms every lane product and registers the per-half and fused results. The pack stage picks the fused or split result and drives the output. A multiply presented with `in_valid` high comes out exactly three clock edges later with `out_valid` high. This holds in every mode, one result per cycle, with no backpressure. The only control states are the three per-stage valid flags. Each flag moves from idle to busy when a valid operation enters its stage. It moves from busy to idle when no operation follows. Reset puts all three flags in idle.

Top module: `lpm_mul`

## Requirements
- R1: `out_valid` is high at the third rising clock edge after the edge at which `in_valid` was sampled high, and low otherwise. This holds for every mode, including back-to-back operations, which come out in issue order.
- R2: While `rst_n` is low and after it is released, `out_valid` stays low until an operation has passed through the pipeline.
- R3: `part_mode` has three fields. Bit 4 set fuses both halves into one 64-bit lane. Bits [1:0] set the lower half's lane size and bits [3:2] the upper half's: 0 means 8-bit lanes, 1 means 16-bit lanes, and 2 or 3 mean one 32-bit lane.
- R4: The operation codes are 0 = low half of the product, 1 = high half with both operands signed, 2 = high half with the first operand signed and the second unsigned, and 3 = high half with both operands unsigned. The signedness applies to each lane separately.
- R5: In 8-bit mode, each byte of the result is the chosen half of the product of the matching operand bytes.
- R6: In 16-bit mode, each 16-bit field of the result is the chosen half of the product of the matching operand fields.
- R7: In 32-bit mode, each 32-bit half of the result is the chosen half of the product of the matching operand words.
- R8: In fused mode, the result is the low or high 64 bits of the 128-bit product, chosen by `op_lo`. `op_hi` and the two size fields are ignored.
- R9: The two halves are independent. Each uses its own size field and its own code, so mixed sizes and mixed codes in either order give the per-half results of R5 to R7.
- R10: Lanes are isolated. With both operands all ones in 8-bit lanes, code 0 gives 0x01 in every byte, code 3 gives 0xFE and code 1 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and control are valid this cycle |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| part_mode | input | 5 | Fuse bit [4], upper size [3:2], lower size [1:0] |
| op_lo | input | 2 | Operation code for bits [31:0], and for the fused lane |
| op_hi | input | 2 | Operation code for bits [63:32] |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Packed lane results |

## Verification
The bench builds the block with its default parameters: a 64-bit data width and an 8-bit minimum lane. This gives three lane sizes in each half plus the fused 64-bit path. With these values every size pairing, including the mixed orders, can be driven through the two halves. Sign-boundary operands such as 0x80 and all ones are reachable in every lane width. The expected results come from an arbitrary-width model of the requirements that extends each lane to 130 bits.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Per-lane operation: low product or one of three high-product signedness rules
    typedef enum logic [1:0] {
        OP_LOW  = 2'd0,
        OP_HSS  = 2'd1,
        OP_HSU  = 2'd2,
        OP_HUU  = 2'd3
    } mul_op_e;

    // Control captured with the operands
    typedef struct packed {
        logic       fuse;
        logic [1:0] sz_hi;
        logic [1:0] sz_lo;
        mul_op_e    op_hi;
        mul_op_e    op_lo;
    } ctl_t;

endpackage

// File: rtl/lpm_lane.sv
// One lane of width LW: signed/unsigned extension, product, half selection.
module lpm_lane #(
    parameter int unsigned LW = 8
) (
    input  logic [LW-1:0]    a_i,
    input  logic [LW-1:0]    b_i,
    input  lpm_pkg::mul_op_e op_i,
    output logic [LW-1:0]    r_o
);
    import lpm_pkg::*;

    localparam int unsigned PW = 2 * LW;

    logic              a_neg;
    logic              b_neg;
    logic signed [LW:0] a_x;
    logic signed [LW:0] b_x;
    logic [PW-1:0]     prod;

    always_comb begin
        a_neg = (op_i == OP_HSS || op_i == OP_HSU) && a_i[LW-1];
        b_neg = (op_i == OP_HSS) && b_i[LW-1];
        a_x   = $signed({a_neg, a_i});
        b_x   = $signed({b_neg, b_i});
        // product modulo 2^PW is exact for both returned halves
        prod  = PW'(PW'(a_x) * PW'(b_x));
        r_o   = (op_i == OP_LOW) ? prod[LW-1:0] : prod[PW-1:LW];
    end
endmodule

// File: rtl/lpm_half.sv
// One half of the datapath: a bank of lanes for every lane size, then a size pick.
module lpm_half #(
    parameter int unsigned HW   = 32,
    parameter int unsigned MINW = 8
) (
    input  logic [HW-1:0]    a_i,
    input  logic [HW-1:0]    b_i,
    input  lpm_pkg::mul_op_e op_i,
    input  logic [1:0]       sz_i,
    output logic [HW-1:0]    r_o
);
    localparam int unsigned NSZ = $clog2(HW / MINW) + 1;

    logic [NSZ-1:0][HW-1:0] by_sz;

    for (genvar s = 0; s < NSZ; s++) begin : g_sz
        localparam int unsigned LW = MINW << s;
        localparam int unsigned NL = HW / LW;
        for (genvar k = 0; k < NL; k++) begin : g_ln
            lpm_lane #(.LW(LW)) u_lane (
                .a_i  (a_i[k*LW +: LW]),
                .b_i  (b_i[k*LW +: LW]),
                .op_i (op_i),
                .r_o  (by_sz[s][k*LW +: LW])
            );
        end
    end

    // size codes beyond the widest lane fall back to the widest lane
    always_comb begin
        r_o = by_sz[NSZ-1];
        for (int s = 0; s < NSZ; s++) begin
            if (int'(sz_i) == s) r_o = by_sz[s];
        end
    end
endmodule

// File: rtl/lpm_mul.sv
// Top: capture -> multiply -> pack, fixed three-edge latency.
module lpm_mul #(
    parameter int unsigned DW   = 64,
    parameter int unsigned MINW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [4:0]    part_mode,
    input  logic [1:0]    op_lo,
    input  logic [1:0]    op_hi,
    output logic          out_valid,
    output logic [DW-1:0] result
);
    import lpm_pkg::*;

    localparam int unsigned HW = DW / 2;

    // capture stage
    logic          cap_v;
    logic [DW-1:0] cap_a;
    logic [DW-1:0] cap_b;
    ctl_t          cap_ctl;
    ctl_t          ctl_in;

    // multiply stage
    logic          mul_v;
    logic          mul_fuse;
    logic [HW-1:0] mul_lo;
    logic [HW-1:0] mul_hi;
    logic [DW-1:0] mul_wide;

    logic [HW-1:0] lo_r;
    logic [HW-1:0] hi_r;
    logic [DW-1:0] wide_r;

    always_comb begin
        ctl_in.fuse  = part_mode[4];
        ctl_in.sz_hi = part_mode[3:2];
        ctl_in.sz_lo = part_mode[1:0];
        ctl_in.op_hi = mul_op_e'(op_hi);
        ctl_in.op_lo = mul_op_e'(op_lo);
    end

    lpm_half #(.HW(HW), .MINW(MINW)) u_half_lo (
        .a_i  (cap_a[HW-1:0]),
        .b_i  (cap_b[HW-1:0]),
        .op_i (cap_ctl.op_lo),
        .sz_i (cap_ctl.sz_lo),
        .r_o  (lo_r)
    );

    lpm_half #(.HW(HW), .MINW(MINW)) u_half_hi (
        .a_i  (cap_a[DW-1:HW]),
        .b_i  (cap_b[DW-1:HW]),
        .op_i (cap_ctl.op_hi),
        .sz_i (cap_ctl.sz_hi),
        .r_o  (hi_r)
    );

    lpm_lane #(.LW(DW)) u_wide (
        .a_i  (cap_a),
        .b_i  (cap_b),
        .op_i (cap_ctl.op_lo),
        .r_o  (wide_r)
    );

    // stage valid flags: idle/busy per stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_v     <= 1'b0;
            mul_v     <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            cap_v     <= in_valid;
            mul_v     <= cap_v;
            out_valid <= mul_v;
        end
    end

    // data path registers
    always_ff @(posedge clk) begin
        cap_a    <= opa;
        cap_b    <= opb;
        cap_ctl  <= ctl_in;
        mul_fuse <= cap_ctl.fuse;
        mul_lo   <= lo_r;
        mul_hi   <= hi_r;
        mul_wide <= wide_r;
        result   <= mul_fuse ? mul_wide : {mul_hi, mul_lo};
    end
endmodule

// File: rtl/lpm_mul_chk.sv
// Checker for lpm_mul: keeps its own three-deep input history.
module lpm_mul_chk #(
    parameter int unsigned DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] opa,
    input logic [DW-1:0] opb,
    input logic          fuse_i,
    input logic [1:0]    lo_sz_i,
    input logic [1:0]    op_lo_i,
    input logic          out_valid,
    input logic [DW-1:0] result
);
    logic [2:0]    hv;
    logic [DW-1:0] ha [3];
    logic [DW-1:0] hb [3];
    logic          hf [3];
    logic [1:0]    hs [3];
    logic [1:0]    ho [3];

    logic [DW-1:0] p_full;
    logic [31:0]   p_word;
    logic [7:0]    p_b0;
    logic [7:0]    p_b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hv <= '0;
        else        hv <= {hv[1:0], in_valid};
    end

    always_ff @(posedge clk) begin
        ha[0] <= opa;
        hb[0] <= opb;
        hf[0] <= fuse_i;
        hs[0] <= lo_sz_i;
        ho[0] <= op_lo_i;
        for (int i = 1; i < 3; i++) begin
            ha[i] <= ha[i-1];
            hb[i] <= hb[i-1];
            hf[i] <= hf[i-1];
            hs[i] <= hs[i-1];
            ho[i] <= ho[i-1];
        end
    end

    assign p_full = ha[2] * hb[2];
    assign p_word = ha[2][31:0] * hb[2][31:0];
    assign p_b0   = ha[2][7:0] * hb[2][7:0];
    assign p_b1   = ha[2][15:8] * hb[2][15:8];

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hv[2]);

    assert_idle_in_reset_R2: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

    assert_fused_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hf[2] && ho[2] == 2'd0) |-> result == p_full);

    assert_word_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hf[2] && hs[2] == 2'd2 && ho[2] == 2'd0) |-> result[31:0] == p_word);

    assert_byte_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hf[2] && hs[2] == 2'd0 && ho[2] == 2'd0)
        |-> (result[7:0] == p_b0 && result[15:8] == p_b1));
endmodule

bind lpm_mul lpm_mul_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .fuse_i    (part_mode[4]),
    .lo_sz_i   (part_mode[1:0]),
    .op_lo_i   (op_lo),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_lpm_mul.sv
module test_lpm_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [4:0]  part_mode = '0;
    logic [1:0]  op_lo = '0;
    logic [1:0]  op_hi = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [63:0] VA = 64'h80F3_7F01_FFFF_0080;
    localparam logic [63:0] VB = 64'h7F85_8001_FFFE_80FF;
    localparam logic [63:0] VC = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] VD = 64'hFEDC_BA98_7654_3210;

    always #2 clk = ~clk;

    lpm_mul #(.DW(64)) i_lpm_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .part_mode(part_mode), .op_lo(op_lo), .op_hi(op_hi),
        .out_valid(out_valid), .result(result)
    );

    // model of one lane of width L from the requirements (R4)
    function automatic logic [63:0] lane_ref(input logic [63:0] a, input logic [63:0] b,
                                             input int L, input logic [1:0] op);
        logic [63:0]        m;
        logic signed [129:0] x, y, p, q;
        m = (L == 64) ? {64{1'b1}} : ((64'd1 << L) - 64'd1);
        x = {66'd0, a & m};
        y = {66'd0, b & m};
        if ((op == 2'd1 || op == 2'd2) && a[L-1]) x = x - (130'sd1 <<< L);
        if (op == 2'd1 && b[L-1]) y = y - (130'sd1 <<< L);
        p = x * y;
        q = p >> L;
        lane_ref = (op == 2'd0) ? (p[63:0] & m) : (q[63:0] & m);
    endfunction

    function automatic logic [63:0] pack_ref(input logic [63:0] a, input logic [63:0] b,
                                             input logic [4:0] mode, input logic [1:0] opl,
                                             input logic [1:0] oph);
        logic [63:0] r;
        if (mode[4]) return lane_ref(a, b, 64, opl);
        r = '0;
        for (int h = 0; h < 2; h++) begin
            int code = (h == 1) ? int'(mode[3:2]) : int'(mode[1:0]);
            int L    = 8 << ((code > 2) ? 2 : code);
            logic [1:0] op = (h == 1) ? oph : opl;
            for (int k = 0; k < 32 / L; k++) begin
                int pos = h * 32 + k * L;
                r = r | (lane_ref(a >> pos, b >> pos, L, op) << pos);
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one isolated operation; checks the valid pulse and the result
    task automatic run_one(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input logic [4:0] mode, input logic [1:0] opl, input logic [1:0] oph,
                           input logic [63:0] exp);
        @(negedge clk);
        opa = a; opb = b; part_mode = mode; op_lo = opl; op_hi = oph; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        opa = ~a; opb = ~b;
        chk({tag, " R1 early"}, {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk({tag, " R1 valid"}, {63'd0, out_valid}, 64'd1);
        chk(tag, result, exp);
        @(negedge clk);
        chk({tag, " R1 pulse end"}, {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_reset_R2();
        repeat (3) @(negedge clk);
        chk("R2 during reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 after release", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_bytes_R5();
        for (int op = 0; op < 4; op++) begin
            run_one($sformatf("R5 R4 bytes op%0d", op), VA, VB, 5'b0_00_00,
                    2'(op), 2'(op), pack_ref(VA, VB, 5'b0_00_00, 2'(op), 2'(op)));
        end
    endtask

    task automatic t_halves_R6();
        for (int op = 0; op < 4; op++) begin
            run_one($sformatf("R6 R4 halves op%0d", op), VA, VB, 5'b0_01_01,
                    2'(op), 2'(3 - op), pack_ref(VA, VB, 5'b0_01_01, 2'(op), 2'(3 - op)));
        end
    endtask

    task automatic t_words_R7();
        for (int op = 0; op < 4; op++) begin
            run_one($sformatf("R7 words op%0d", op), VC, VD, 5'b0_10_10,
                    2'(op), 2'(op), pack_ref(VC, VD, 5'b0_10_10, 2'(op), 2'(op)));
        end
        // R3: size code 3 behaves as a 32-bit lane
        run_one("R3 code3 as word", VA, VB, 5'b0_11_11, 2'd1, 2'd2,
                pack_ref(VA, VB, 5'b0_10_10, 2'd1, 2'd2));
    endtask

    task automatic t_fused_R8();
        for (int op = 0; op < 4; op++) begin
            run_one($sformatf("R8 fused op%0d", op), VA, VD, 5'b1_00_01,
                    2'(op), 2'(~op), pack_ref(VA, VD, 5'b1_10_10, 2'(op), 2'(op)));
        end
        run_one("R8 fused most negative squared", 64'h8000_0000_0000_0000,
                64'h8000_0000_0000_0000, 5'b1_01_00, 2'd1, 2'd3, 64'h4000_0000_0000_0000);
        run_one("R8 fused ones hsu", {64{1'b1}}, {64{1'b1}}, 5'b1_10_10, 2'd2, 2'd0,
                {64{1'b1}});
    endtask

    task automatic t_mixed_R9();
        run_one("R9 word lo half hi", VC, VB, 5'b0_01_10, 2'd2, 2'd1,
                pack_ref(VC, VB, 5'b0_01_10, 2'd2, 2'd1));
        run_one("R9 half lo word hi", VC, VB, 5'b0_10_01, 2'd1, 2'd2,
                pack_ref(VC, VB, 5'b0_10_01, 2'd1, 2'd2));
        run_one("R9 byte lo word hi", VA, VD, 5'b0_10_00, 2'd3, 2'd0,
                pack_ref(VA, VD, 5'b0_10_00, 2'd3, 2'd0));
        run_one("R9 word lo byte hi", VA, VD, 5'b0_00_10, 2'd0, 2'd3,
                pack_ref(VA, VD, 5'b0_00_10, 2'd0, 2'd3));
    endtask

    task automatic t_isolation_R10();
        run_one("R10 ones low", {64{1'b1}}, {64{1'b1}}, 5'b0_00_00, 2'd0, 2'd0,
                64'h0101_0101_0101_0101);
        run_one("R10 ones huu", {64{1'b1}}, {64{1'b1}}, 5'b0_00_00, 2'd3, 2'd3,
                64'hFEFE_FEFE_FEFE_FEFE);
        run_one("R10 ones hss", {64{1'b1}}, {64{1'b1}}, 5'b0_00_00, 2'd1, 2'd1,
                64'h0000_0000_0000_0000);
    endtask

    // back-to-back stream with mixed modes: order and exact latency (R1)
    task automatic t_stream_R1();
        logic [63:0] sa [4];
        logic [63:0] sb [4];
        logic [4:0]  sm [4];
        logic [1:0]  so [4];
        logic [63:0] se [4];
        sa = '{VA, VC, VB, VD};
        sb = '{VB, VD, VA, VC};
        sm = '{5'b0_00_10, 5'b1_00_00, 5'b0_01_00, 5'b0_10_01};
        so = '{2'd1, 2'd3, 2'd2, 2'd0};
        for (int i = 0; i < 4; i++) se[i] = pack_ref(sa[i], sb[i], sm[i], so[i], ~so[i]);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 3 && c < 7) begin
                chk($sformatf("R1 stream valid %0d", c - 3), {63'd0, out_valid}, 64'd1);
                chk($sformatf("R1 stream result %0d", c - 3), result, se[c - 3]);
            end else begin
                chk($sformatf("R1 stream idle %0d", c), {63'd0, out_valid}, 64'd0);
            end
            if (c < 4) begin
                opa = sa[c]; opb = sb[c]; part_mode = sm[c];
                op_lo = so[c]; op_hi = ~so[c]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #1 rst_n = 1'b0;
        t_reset_R2();
        t_bytes_R5();
        t_halves_R6();
        t_words_R7();
        t_fused_R8();
        t_mixed_R9();
        t_isolation_R10();
        t_stream_R1();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule